// File: doc/BRIEF.md
# Settable BCD Time-of-Day Counter

This block keeps a 24-hour time of day in four BCD digits: hours tens, hours units, minutes tens and minutes units. It runs from a 32768 Hz reference clock. A free-running binary prescaler turns that clock into a 2 Hz enable pulse. Every register is clocked by the reference clock and changes only in the cycle after that pulse. No register uses a derived clock, and no register has an asynchronous reset.

Seconds are kept as a binary count of half-seconds from 0 to 119. Using a 2 Hz rate for both timekeeping and setting means holding a set button steps a digit twice a second. Three level inputs set the time. These inputs must already be debounced and synchronized.

- The hours input steps the hours.
- The minutes input steps the minutes.
- The seconds input clears and freezes the half-second count.

A blink output gives a 1 Hz square wave for the seconds indicator. Decoding to segments and driving the display are left to the logic that uses this block.

Top module: `tod_counter`

## Requirements
- R1: The prescaler is PRESC_W bits wide and starts from 0 after reset. Its top bit rises once every 2^PRESC_W reference cycles, and each rising edge gives a one-cycle tick. After reset is released, the first tick is present in cycle 2^(PRESC_W-1). Time registers update only on the clock edge that ends a tick cycle.
- R2: A synchronous active-high reset clears the prescaler, the half-second count and all four digits, so the outputs show 00:00 with blink at 0.
- R3: On each tick, the half-second count advances by one from 0 up to 119 and then wraps to 0. A tick seen while the count is 119 produces the minute carry, whether or not the seconds input is held.
- R4: On a minute carry, minutes units step through 0..9 and minutes tens step through 0..5. The tens digit advances only when the units wrap from 9. When a minute carry arrives at xx:59, the minutes go to 00 and the hours advance by one.
- R5: Hours units count 0..9 while hours tens is 0 or 1, and 0..3 while hours tens is 2. Hours tens advances when the units wrap. An hour advance at 23 gives 00, so 09 goes to 10, 19 goes to 20 and 23 goes to 00.
- R6: While the hours input is high, the hours advance by one on every tick following R5. The minutes digits are left untouched apart from their normal minute carry.
- R7: While the minutes input is high, the minutes advance by one on every tick and wrap from 59 to 00. A wrap caused by the button gives no carry into the hours. A tick that also brings a minute carry still advances the minutes by exactly one.
- R8: While the seconds input is high, each tick forces the half-second count to 0, so blink stays at 0 and the minute carry stops.
- R9: Blink is bit 0 of the half-second count. It toggles on every tick, giving a 1 Hz output with 50% duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| set_hrs | input | 1 | Level: step hours on every tick |
| set_min | input | 1 | Level: step minutes on every tick |
| hold_sec | input | 1 | Level: clear and freeze the half-second count |
| min_ones | output | 4 | Minutes units, BCD 0..9 |
| min_tens | output | 3 | Minutes tens, 0..5 |
| hrs_ones | output | 4 | Hours units, BCD 0..9 |
| hrs_tens | output | 2 | Hours tens, 0..2 |
| blink | output | 1 | Seconds blink, 1 Hz |

## Verification
The bench first steers the clock to 09:59, 19:59 and 23:59 and lets it roll over. A design that used a fixed limit of 9 for the hours units would show 24:00 instead of midnight. A design that carried the tens badly would skip 10 or 20.

Holding the minutes input through a 59-to-00 wrap catches a design that lets the button carry into the hours. Holding the hours input through 23 catches the same wrong units limit.

Holding the seconds input catches a design that merely pauses the count instead of clearing it, because blink would then stay at 1. A reset in the middle of a run catches a prescaler that keeps its phase, because the first tick after reset would land in the wrong cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int HALF_SEC_LAST = 119;
    localparam int HALF_SEC_W    = $clog2(HALF_SEC_LAST + 1);
    localparam int MIN_ONES_W    = 4;
    localparam int MIN_TENS_W    = 3;
    localparam int HRS_ONES_W    = 4;
    localparam int HRS_TENS_W    = 2;

    localparam logic [MIN_ONES_W-1:0] MIN_ONES_LAST = 4'd9;
    localparam logic [MIN_TENS_W-1:0] MIN_TENS_LAST = 3'd5;
    localparam logic [HRS_TENS_W-1:0] HRS_TENS_LAST = 2'd2;
    localparam logic [HRS_ONES_W-1:0] HRS_ONES_FULL = 4'd9;
    localparam logic [HRS_ONES_W-1:0] HRS_ONES_DAY  = 4'd3;

    typedef struct packed {
        logic [HRS_TENS_W-1:0] hrs_tens;
        logic [HRS_ONES_W-1:0] hrs_ones;
        logic [MIN_TENS_W-1:0] min_tens;
        logic [MIN_ONES_W-1:0] min_ones;
    } tod_t;

    // Hours units stop at 3 once the tens digit has reached its own limit.
    function automatic logic [HRS_ONES_W-1:0] hrs_ones_limit(input logic tens_at_last);
        return tens_at_last ? HRS_ONES_DAY : HRS_ONES_FULL;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int PRESC_W = 14
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TOP = PRESC_W - 1;

    logic [PRESC_W-1:0] count_q;
    logic               top_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            top_q   <= 1'b0;
        end else begin
            count_q <= count_q + 1'b1;
            top_q   <= count_q[TOP];
        end
    end

    // One-cycle pulse on the rising transition of the top bit.
    assign tick = count_q[TOP] & ~top_q;

endmodule

// File: rtl/tod_halfsec.sv
module tod_halfsec #(
    parameter int W    = 7,
    parameter int LAST = 119
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic         carry
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] count_q;
    logic         at_last;

    assign at_last = (count_q == LAST_V);
    assign carry   = tick & at_last;
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick) begin
            if (clear || at_last) count_q <= '0;
            else                  count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/tod_digit.sv
module tod_digit #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic [W-1:0] last,
    output logic [W-1:0] value,
    output logic         at_last
);
    logic [W-1:0] value_q;

    assign value   = value_q;
    assign at_last = (value_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (inc) begin
            if (at_last) value_q <= '0;
            else         value_q <= value_q + 1'b1;
        end
    end

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int PRESC_W = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_hrs,
    input  logic                  set_min,
    input  logic                  hold_sec,
    output logic [MIN_ONES_W-1:0] min_ones,
    output logic [MIN_TENS_W-1:0] min_tens,
    output logic [HRS_ONES_W-1:0] hrs_ones,
    output logic [HRS_TENS_W-1:0] hrs_tens,
    output logic                  blink
);
    logic                  tick;
    logic [HALF_SEC_W-1:0] half_sec;
    logic                  sec_carry;
    tod_t                  now;

    logic mo_last, mt_last, ho_last, ht_last;
    logic mo_inc, mt_inc, ho_inc, ht_inc;
    logic [HRS_ONES_W-1:0] ho_limit;

    tod_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    tod_halfsec #(.W(HALF_SEC_W), .LAST(HALF_SEC_LAST)) half_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .clear (hold_sec),
        .count (half_sec),
        .carry (sec_carry)
    );

    // Minutes step on the natural carry or once per tick while set_min is held.
    assign mo_inc = sec_carry | (tick & set_min);
    assign mt_inc = mo_inc & mo_last;
    // Only the natural carry reaches the hours; the minutes button never does.
    assign ho_inc = (sec_carry & mo_last & mt_last) | (tick & set_hrs);
    assign ht_inc = ho_inc & ho_last;
    assign ho_limit = hrs_ones_limit(ht_last);

    tod_digit #(.W(MIN_ONES_W)) mo_i (
        .clk (clk), .rst (rst), .inc (mo_inc), .last (MIN_ONES_LAST),
        .value (now.min_ones), .at_last (mo_last)
    );

    tod_digit #(.W(MIN_TENS_W)) mt_i (
        .clk (clk), .rst (rst), .inc (mt_inc), .last (MIN_TENS_LAST),
        .value (now.min_tens), .at_last (mt_last)
    );

    tod_digit #(.W(HRS_ONES_W)) ho_i (
        .clk (clk), .rst (rst), .inc (ho_inc), .last (ho_limit),
        .value (now.hrs_ones), .at_last (ho_last)
    );

    tod_digit #(.W(HRS_TENS_W)) ht_i (
        .clk (clk), .rst (rst), .inc (ht_inc), .last (HRS_TENS_LAST),
        .value (now.hrs_tens), .at_last (ht_last)
    );

    assign min_ones = now.min_ones;
    assign min_tens = now.min_tens;
    assign hrs_ones = now.hrs_ones;
    assign hrs_tens = now.hrs_tens;
    assign blink    = half_sec[0];

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       set_hrs,
    input logic       hold_sec,
    input logic [3:0] min_ones,
    input logic [2:0] min_tens,
    input logic [3:0] hrs_ones,
    input logic [1:0] hrs_tens,
    input logic       blink
);

    // R2: reset yields 00:00 with blink low
    assert_reset_clears_R2: assert property (@(posedge clk)
        rst |=> (min_ones == 4'd0 && min_tens == 3'd0 && hrs_ones == 4'd0
                 && hrs_tens == 2'd0 && !blink));

    // R1: tick is a single-cycle pulse
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R1: without a tick the time does not move
    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(min_ones) && $stable(min_tens) && $stable(hrs_ones)
                   && $stable(hrs_tens) && $stable(blink)));

    // R4: minutes digits in range
    assert_min_range_R4: assert property (@(posedge clk) disable iff (rst)
        (min_ones <= 4'd9 && min_tens <= 3'd5));

    // R5: hours digits in range, never past 23
    assert_hrs_range_R5: assert property (@(posedge clk) disable iff (rst)
        (hrs_tens <= 2'd2 && (hrs_tens != 2'd2 || hrs_ones <= 4'd3)));

    // R8: holding seconds clears the count, so blink is low after the tick
    assert_hold_sec_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && hold_sec) |=> !blink);

    // R9: blink toggles on every tick unless seconds are held
    assert_blink_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold_sec) |=> (blink != $past(blink)));

    // R6: hours units step by one on a set tick away from any wrap
    assert_set_hrs_step_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && set_hrs && hrs_ones != 4'd9 && !(hrs_tens == 2'd2 && hrs_ones == 4'd3))
        |=> (hrs_ones == $past(hrs_ones) + 4'd1));

endmodule

bind tod_counter tod_counter_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .set_hrs  (set_hrs),
    .hold_sec (hold_sec),
    .min_ones (min_ones),
    .min_tens (min_tens),
    .hrs_ones (hrs_ones),
    .hrs_tens (hrs_tens),
    .blink    (blink)
);

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;

    localparam int PW     = 2;
    localparam int PERIOD = 1 << PW;
    localparam int PHASE  = 1 << (PW - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_hrs = 1'b0, set_min = 1'b0, hold_sec = 1'b0;
    logic [3:0] min_ones, hrs_ones;
    logic [2:0] min_tens;
    logic [1:0] hrs_tens;
    logic       blink;

    int tests = 0, fails = 0;
    string cur_req = "R2";
    bit done = 0;

    // reference model state
    int m_cyc = 0, m_half = 0, m_mo = 0, m_mt = 0, m_ho = 0, m_ht = 0;

    always #2 clk = ~clk;

    tod_counter #(.PRESC_W(PW)) dut_i (
        .clk(clk), .rst(rst), .set_hrs(set_hrs), .set_min(set_min),
        .hold_sec(hold_sec), .min_ones(min_ones), .min_tens(min_tens),
        .hrs_ones(hrs_ones), .hrs_tens(hrs_tens), .blink(blink)
    );

    function automatic int hour_limit(input int tens);
        return (tens == 2) ? 3 : 9;
    endfunction

    task automatic model_step();
        bit carry, hour_adv;
        carry    = (m_half == 119);
        hour_adv = (carry && m_mo == 9 && m_mt == 5) || set_hrs;
        m_half   = hold_sec ? 0 : (carry ? 0 : m_half + 1);
        if (carry || set_min) begin
            if (m_mo == 9) begin
                m_mo = 0;
                m_mt = (m_mt == 5) ? 0 : m_mt + 1;
            end else m_mo++;
        end
        if (hour_adv) begin
            if (m_ho == hour_limit(m_ht)) begin
                m_ho = 0;
                m_ht = (m_ht == 2) ? 0 : m_ht + 1;
            end else m_ho++;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_half = 0; m_mo = 0; m_mt = 0; m_ho = 0; m_ht = 0;
        end else begin
            if ((m_cyc % PERIOD) == PHASE) model_step();
            m_cyc++;
        end
    end

    task automatic check_now();
        int act, exp;
        act = {hrs_tens, hrs_ones, 1'b0, min_tens, min_ones, blink};
        exp = {m_ht[1:0], m_ho[3:0], 1'b0, m_mt[2:0], m_mo[3:0], m_half[0]};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d%0d:%0d%0d blink=%0b, expected %0d%0d:%0d%0d blink=%0b",
                     cur_req, hrs_tens, hrs_ones, min_tens, min_ones, blink,
                     m_ht, m_ho, m_mt, m_mo, m_half[0]);
        end
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic steer(input int h, input int m);
        set_hrs = 1'b1;
        while (hrs_tens * 10 + hrs_ones != h) run(1);
        set_hrs = 1'b0;
        set_min = 1'b1;
        while (min_tens * 10 + min_ones != m) run(1);
        set_min = 1'b0;
        hold_sec = 1'b1;
        run(3 * PERIOD);
        hold_sec = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R2: reset state
        repeat (3) @(negedge clk);
        cur_req = "R2"; check_now();
        rst = 1'b0;
        // R1/R9/R3: free run over a minute carry
        cur_req = "R1"; run(3 * PERIOD);
        cur_req = "R3"; run(125 * PERIOD);
        // R7: minutes button through 59->00, no hour carry
        cur_req = "R7"; set_min = 1'b1; run(70 * PERIOD); set_min = 1'b0;
        // R6: hours button through 23->00
        cur_req = "R6"; set_hrs = 1'b1; run(30 * PERIOD); set_hrs = 1'b0;
        // R8: seconds freeze
        cur_req = "R8"; run(5 * PERIOD + 1); hold_sec = 1'b1; run(10 * PERIOD); hold_sec = 1'b0;
        cur_req = "R9"; run(6 * PERIOD);
        // R4/R5: natural rollovers
        cur_req = "R4"; steer(9, 59); run(122 * PERIOD);
        cur_req = "R5"; steer(19, 59); run(122 * PERIOD);
        cur_req = "R5"; steer(23, 59); run(122 * PERIOD);
        // R7: button held across a natural carry gives a single step
        cur_req = "R7"; steer(5, 30); run(118 * PERIOD);
        set_min = 1'b1; run(4 * PERIOD); set_min = 1'b0;
        // R6: random mix of buttons
        cur_req = "R6";
        for (int k = 0; k < 300; k++) begin
            int r;
            r = $urandom;
            set_hrs  = (r[3:0] == 0);
            set_min  = (r[7:4] < 3);
            hold_sec = (r[11:8] == 0);
            run(1 + int'(r[14:12]));
        end
        set_hrs = 1'b0; set_min = 1'b0; hold_sec = 1'b0;
        cur_req = "R3"; run(130 * PERIOD);
        // R2: mid-run reset, then R1 phase of first tick
        cur_req = "R2"; rst = 1'b1; run(2);
        rst = 1'b0;
        cur_req = "R1"; run(6 * PERIOD);
        finish_run();
    end

endmodule